// File: doc/BRIEF.md
# Section clock-stop controller

This block holds one small control register and turns its contents into clock-enable signals for four sections of a mixed-signal baseband device. The sections are the receive-data serial interface, the auxiliary converter section, the command serial interface and the receive data path. Each enable is a synchronous, active-high level. It is meant to drive a clock-gating cell, or a clock-enable input, that sits outside the block.

Software writes the register through a simple port made of write enable, read enable, a 7-bit address and 8 bits of data. Two sections are stopped directly by register bits. The receive data path clock can be handed over to an external receive-enable flag. The command serial interface can stop itself: in low-data-rate mode, once no frame-sync strobe has been seen for a programmable number of master-clock cycles (4096 by default), its clock stops. The next frame-sync strobe restarts it.

Top module: `clkstop_ctrl`

## Requirements
- R1: A write with `reg_addr` = 0x3C captures `reg_wdata[3:0]` into the control field at that clock edge. A read with `reg_re` high and `reg_addr` = 0x3C returns the field on `reg_rdata[3:0]` in the same cycle. The field layout is: bit 3 receive-interface stop, bit 2 auxiliary stop, bit 1 automatic-stop enable, bit 0 receive-path gate.
- R2: `reg_rdata[7:4]` always reads 0, and `reg_wdata[7:4]` is discarded. Writes to any address other than 0x3C leave the field unchanged. `reg_rdata` is 0 whenever `reg_re` is low or the address is not 0x3C.
- R3: While bit 3 is 1, `rxif_clk_en` is 0. It stays 0 until a write clears bit 3, and it is 1 while bit 3 is 0.
- R4: `aux_clk_en` equals the inverse of bit 2.
- R5: `rxpath_clk_en` is 1 when bit 0 is 0. When bit 0 is 1, `rxpath_clk_en` follows `rx_enable`.
- R6: While bit 1 is 1 and `rate_high` is 0, `cmdif_clk_en` goes to 0 right after the IDLE_CYCLES-th consecutive rising edge at which `frame_sync` was sampled 0. It stays 0 until woken.
- R7: A `frame_sync` sampled high at a rising edge restarts the idle count. If the interface was stopped, `cmdif_clk_en` is 1 after that edge.
- R8: When `rate_high` is 1 or bit 1 is 0, `cmdif_clk_en` is 1 in that same cycle, with no clock edge needed. The idle count is cleared, so a later stop again needs a full IDLE_CYCLES window.
- R9: After reset, all four control bits are 0 and all four clock enables are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 7 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational |
| frame_sync | input | 1 | Command-interface frame-sync strobe |
| rate_high | input | 1 | High-data-rate mode flag; disables the automatic stop |
| rx_enable | input | 1 | Receive enable, used as the receive-path gate when bit 0 is set |
| rxif_clk_en | output | 1 | Clock enable, receive-data serial interface |
| aux_clk_en | output | 1 | Clock enable, auxiliary converter section |
| cmdif_clk_en | output | 1 | Clock enable, command serial interface |
| rxpath_clk_en | output | 1 | Clock enable, receive data path |

## Verification
A register write takes effect at the edge that samples it. The bench therefore checks the register-driven enables and readback at the falling edge that follows the write. Readback, the receive-path gate and the forced wake on `rate_high` or a cleared bit 1 are combinational, so they are sampled shortly after the inputs change in the same cycle. For the idle stop, the bench counts rising edges from the last one that saw `frame_sync` high. It requires `cmdif_clk_en` to be 1 after edge IDLE_CYCLES-1 and 0 after edge IDLE_CYCLES. The bench uses a reduced window of 16 cycles.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;
  localparam int ADDR_W = 7;
  localparam int DATA_W = 8;
  localparam int CTL_W  = 4;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = 7'h3C;

  // Field order is decoded by software: bit 3 down to bit 0.
  typedef struct packed {
    logic rxif_stop;
    logic aux_stop;
    logic auto_stop;
    logic rxpath_gate;
  } ctrl_t;
endpackage

// File: rtl/clkstop_rst_sync.sv
module clkstop_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/clkstop_regs.sv
module clkstop_regs
  import clkstop_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output ctrl_t             ctrl,
  output logic [DATA_W-1:0] rdata
);
  ctrl_t ctrl_q;
  ctrl_t ctrl_d;
  logic  hit;
  logic  load_en;

  always_comb begin
    hit     = (addr == CTRL_ADDR);
    load_en = we && hit;
    ctrl_d  = ctrl_t'(wdata[CTL_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (load_en) begin
      ctrl_q <= ctrl_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (re && hit) begin
      rdata[CTL_W-1:0] = ctrl_q;
    end
  end

  assign ctrl = ctrl_q;
endmodule

// File: rtl/clkstop_idle_timer.sv
module clkstop_idle_timer #(
  parameter int IDLE_CYCLES = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic sync,
  output logic stopped
);
  localparam int CNT_W = (IDLE_CYCLES > 2) ? $clog2(IDLE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] TERM = CNT_W'(IDLE_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             stop_q, stop_d;
  logic             upd_en;

  always_comb begin
    cnt_d  = cnt_q;
    stop_d = stop_q;
    if (!arm || sync) begin
      cnt_d  = '0;
      stop_d = 1'b0;
    end else if (!stop_q) begin
      if (cnt_q == TERM) begin
        stop_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
    upd_en = (cnt_d != cnt_q) || (stop_d != stop_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      stop_q <= 1'b0;
    end else if (upd_en) begin
      cnt_q  <= cnt_d;
      stop_q <= stop_d;
    end
  end

  assign stopped = stop_q;
endmodule

// File: rtl/clkstop_gates.sv
module clkstop_gates
  import clkstop_pkg::*;
(
  input  ctrl_t ctrl,
  input  logic  arm,
  input  logic  idle_stopped,
  input  logic  rx_enable,
  output logic  rxif_en,
  output logic  aux_en,
  output logic  cmdif_en,
  output logic  rxpath_en
);
  always_comb begin
    rxif_en   = !ctrl.rxif_stop;
    aux_en    = !ctrl.aux_stop;
    cmdif_en  = !(arm && idle_stopped);
    rxpath_en = !ctrl.rxpath_gate || rx_enable;
  end
endmodule

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl
  import clkstop_pkg::*;
#(
  parameter int IDLE_CYCLES = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              frame_sync,
  input  logic              rate_high,
  input  logic              rx_enable,
  output logic              rxif_clk_en,
  output logic              aux_clk_en,
  output logic              cmdif_clk_en,
  output logic              rxpath_clk_en
);
  logic  rst_sync_n;
  ctrl_t ctrl;
  logic  arm;
  logic  idle_stopped;

  clkstop_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  clkstop_regs u_regs (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .we    (reg_we),
    .re    (reg_re),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .ctrl  (ctrl),
    .rdata (reg_rdata)
  );

  assign arm = ctrl.auto_stop && !rate_high;

  clkstop_idle_timer #(.IDLE_CYCLES(IDLE_CYCLES)) u_idle (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .arm     (arm),
    .sync    (frame_sync),
    .stopped (idle_stopped)
  );

  clkstop_gates u_gates (
    .ctrl         (ctrl),
    .arm          (arm),
    .idle_stopped (idle_stopped),
    .rx_enable    (rx_enable),
    .rxif_en      (rxif_clk_en),
    .aux_en       (aux_clk_en),
    .cmdif_en     (cmdif_clk_en),
    .rxpath_en    (rxpath_clk_en)
  );
endmodule

// File: rtl/clkstop_ctrl_chk.sv
module clkstop_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_we,
  input logic       reg_re,
  input logic [6:0] reg_addr,
  input logic [7:0] reg_wdata,
  input logic [7:0] reg_rdata,
  input logic       frame_sync,
  input logic       rate_high,
  input logic       rx_enable,
  input logic       rxif_clk_en,
  input logic       aux_clk_en,
  input logic       cmdif_clk_en,
  input logic       rxpath_clk_en
);
  logic wr_hit;
  assign wr_hit = reg_we && (reg_addr == 7'h3C);

  // R2
  rdata_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_re && reg_addr == 7'h3C) |-> reg_rdata == 8'h00);

  // R3
  rxif_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && reg_wdata[3]) |=> !rxif_clk_en);

  // R3
  rxif_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rxif_clk_en && !wr_hit) |=> !rxif_clk_en);

  // R4
  aux_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (aux_clk_en == !$past(reg_wdata[2])));

  // R5
  rxpath_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rxpath_clk_en |-> !rx_enable);

  // R6
  cmd_stop_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmdif_clk_en) |-> (!$past(frame_sync) && !rate_high));

  // R7
  cmd_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sync |=> cmdif_clk_en);

  // R8
  cmd_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rate_high |-> cmdif_clk_en);
endmodule

bind clkstop_ctrl clkstop_ctrl_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .reg_we        (reg_we),
  .reg_re        (reg_re),
  .reg_addr      (reg_addr),
  .reg_wdata     (reg_wdata),
  .reg_rdata     (reg_rdata),
  .frame_sync    (frame_sync),
  .rate_high     (rate_high),
  .rx_enable     (rx_enable),
  .rxif_clk_en   (rxif_clk_en),
  .aux_clk_en    (aux_clk_en),
  .cmdif_clk_en  (cmdif_clk_en),
  .rxpath_clk_en (rxpath_clk_en)
);

// File: tb/tb_clkstop_ctrl.sv
`timescale 1ns/1ps
module tb_clkstop_ctrl;
  localparam int IDLE = 16;
  localparam logic [6:0] RA = 7'h3C;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0, reg_re = 1'b0;
  logic [6:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       frame_sync = 1'b1, rate_high = 1'b0, rx_enable = 1'b0;
  logic       rxif_clk_en, aux_clk_en, cmdif_clk_en, rxpath_clk_en;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  clkstop_ctrl #(.IDLE_CYCLES(IDLE)) dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .frame_sync(frame_sync), .rate_high(rate_high), .rx_enable(rx_enable),
    .rxif_clk_en(rxif_clk_en), .aux_clk_en(aux_clk_en),
    .cmdif_clk_en(cmdif_clk_en), .rxpath_clk_en(rxpath_clk_en)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [7:0] d);
    reg_re = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    reg_re = 1'b0;
  endtask

  task automatic fs_pulse();
    @(negedge clk); frame_sync = 1'b1;
    @(negedge clk); frame_sync = 1'b0;
  endtask

  // R6: enable must hold for IDLE-1 edges and drop on edge IDLE
  task automatic idle_window(input string req);
    for (int k = 1; k <= IDLE; k++) begin
      @(negedge clk);
      chk(req, {7'd0, cmdif_clk_en}, (k < IDLE) ? 8'd1 : 8'd0);
    end
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rv;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R9 reset state
    chk("R9 enables", {4'd0, rxif_clk_en, aux_clk_en, cmdif_clk_en, rxpath_clk_en}, 8'h0F);
    rd(RA, rv);
    chk("R9 ctrl", rv, 8'h00);

    // R1 R2 R3 R4 R5 sweep over field, rate and rx_enable
    for (int v = 0; v < 16; v++) begin
      wr(RA, 8'hF0 | 8'(v));
      rd(RA, rv);
      chk("R1 R2 readback", rv, 8'(v));
      for (int m = 0; m < 4; m++) begin
        rate_high = m[0]; rx_enable = m[1];
        #1;
        chk("R3 rxif", {7'd0, rxif_clk_en}, {7'd0, ~v[3]});
        chk("R4 aux", {7'd0, aux_clk_en}, {7'd0, ~v[2]});
        chk("R5 rxpath", {7'd0, rxpath_clk_en}, {7'd0, ~v[0] | m[1]});
        chk("R7 cmd awake", {7'd0, cmdif_clk_en}, 8'd1);
      end
    end
    rate_high = 1'b0;

    // R2 other addresses ignored
    wr(RA, 8'h00);
    for (int a = 0; a < 128; a++) begin
      if (a != 32'h3C) begin
        wr(7'(a), 8'hFF);
        rd(7'(a), rv);
        chk("R2 other read", rv, 8'h00);
        rd(RA, rv);
        chk("R2 other write", rv, 8'h00);
      end
    end
    #1 chk("R2 rdata idle", reg_rdata, 8'h00);

    // R3 stop holds until cleared
    wr(RA, 8'h08);
    repeat (5) @(negedge clk);
    chk("R3 hold", {7'd0, rxif_clk_en}, 8'd0);
    wr(RA, 8'h00);
    chk("R3 release", {7'd0, rxif_clk_en}, 8'd1);

    // R6 idle stop
    wr(RA, 8'h02);
    fs_pulse();
    idle_window("R6 idle stop");
    repeat (5) @(negedge clk);
    chk("R6 stays stopped", {7'd0, cmdif_clk_en}, 8'd0);

    // R7 wake and restart
    fs_pulse();
    chk("R7 wake", {7'd0, cmdif_clk_en}, 8'd1);
    idle_window("R7 restopped");
    fs_pulse();
    repeat (10) @(negedge clk);
    chk("R7 midway", {7'd0, cmdif_clk_en}, 8'd1);
    fs_pulse();
    idle_window("R7 restart count");

    // R8 rate_high forces wake immediately and clears count
    @(negedge clk); rate_high = 1'b1;
    #1 chk("R8 rate wake", {7'd0, cmdif_clk_en}, 8'd1);
    repeat (40) @(negedge clk);
    chk("R8 no stop at high rate", {7'd0, cmdif_clk_en}, 8'd1);
    rate_high = 1'b0;
    idle_window("R8 full window after rate");

    // R8 clearing bit 1 wakes and clears count
    wr(RA, 8'h00);
    chk("R8 bit1 clear wake", {7'd0, cmdif_clk_en}, 8'd1);
    repeat (40) @(negedge clk);
    chk("R8 disabled no stop", {7'd0, cmdif_clk_en}, 8'd1);
    wr(RA, 8'h02);
    idle_window("R8 full window after enable");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule